// File: doc/BRIEF.md
# Odd/Even Parity Serial Character Transmitter

This block sends one character on a single serial output line. Each frame holds a low start bit, the data bits with the least significant bit first, one parity bit and a high stop bit. Bit timing comes from an oversampling enable that runs at eight times the bit rate. An internal counter divides that enable by eight, so every bit lasts exactly eight enable pulses.

A send request first passes through a three-stage synchronising edge filter. A new frame starts only when the request is seen high on two clock edges in a row after it was low, so a single-cycle glitch is rejected. The byte and the parity mode are captured when the frame is launched. The line is held high while idle and during reset. A busy output covers the whole frame, and a one-cycle done strobe marks its end. The parity mode is chosen at run time: 0 selects odd parity and 1 selects even parity.

Top module: `par_serial_tx`

## Requirements
- R1: While busy, `txd` carries the frame in this order: start bit 0, data bits `din[0]` through `din[7]`, the parity bit, then stop bit 1.
- R2: Each frame bit stays on `txd` for exactly eight `os_tick` pulses. The tick divider is cleared at launch, and `txd` changes only on a clock edge at which `os_tick` is high.
- R3: With `req` low beforehand, driving it high for two consecutive clock edges launches a frame. `busy` is 1 and `txd` is 0 after the third edge, counted from the first edge that samples `req` high. A request that is high for only one edge launches nothing. A request held high launches exactly one frame.
- R4: Parity bit: with `even_sel` = 0, the data bits plus the parity bit contain an odd number of ones. With `even_sel` = 1, they contain an even number of ones.
- R5: `busy` is 1 from the launch edge through the last cycle of the stop bit.
- R6: `done` is 1 for exactly one cycle. It rises on the same edge on which `busy` falls, which is the edge of the eighth `os_tick` of the stop bit.
- R7: A request made while `busy` is 1 is ignored, and changes to `din` or `even_sel` during a frame do not alter the frame on the line.
- R8: While `rst` is 1, `txd` is 1 and both `busy` and `done` are 0 after each clock edge.
- R9: While idle, `txd` stays 1 and `os_tick` pulses start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | One-cycle enable at 8x the bit rate |
| req | input | 1 | Send request, edge-filtered |
| din | input | DATA_W | Character to send |
| even_sel | input | 1 | Parity mode: 0 odd, 1 even |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame strobe |

## Verification
The launch is due on the third clock edge after `req` is first sampled high. The bench therefore checks `busy` still low after two edges and checks `busy` high with `txd` low after the third. After launch, every bit boundary falls on the edge of the eighth `os_tick` counted from the previous boundary. The bench generates those pulses itself, with gaps of one to three cycles, and checks `txd` right after each pulse edge: unchanged after pulses one to seven, and the next bit after pulse eight. `done` and the fall of `busy` are checked on the edge of the eighth stop-bit pulse, and `done` is checked clear one cycle later. All sampling happens on falling clock edges.

// File: rtl/par_serial_tx.sv
module par_serial_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              req,
  input  logic [DATA_W-1:0] din,
  input  logic              even_sel,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic [2:0]         req_sr;
  logic [CNT_W-1:0]   tick_cnt;
  logic [IDX_W-1:0]   bit_idx;
  logic [FRAME_W-1:0] shreg;

  wire launch  = req_sr[0] & req_sr[1] & ~req_sr[2] & ~busy;
  wire bit_end = busy & os_tick & (tick_cnt == CNT_W'(OVS - 1));
  wire last    = (bit_idx == IDX_W'(FRAME_W - 1));
  wire par_bit = ^din ^ ~even_sel;

  assign txd = shreg[0];

  always_ff @(posedge clk) begin
    if (rst) req_sr <= '0;
    else     req_sr <= {req_sr[1:0], req};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
    end else if (launch) begin
      tick_cnt <= '0;
    end else if (busy && os_tick) begin
      tick_cnt <= bit_end ? '0 : tick_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '1;
      bit_idx <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= bit_end & last;
      if (launch) begin
        shreg   <= {1'b1, par_bit, din, 1'b0};
        bit_idx <= '0;
        busy    <= 1'b1;
      end else if (bit_end) begin
        shreg   <= {1'b1, shreg[FRAME_W-1:1]};
        bit_idx <= last ? '0 : bit_idx + IDX_W'(1);
        if (last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/par_serial_tx_chk.sv
module par_serial_tx_chk (
  input logic clk,
  input logic rst,
  input logic os_tick,
  input logic txd,
  input logic busy,
  input logic done
);
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd); // R1

  AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(os_tick)) |-> $stable(txd)); // R2

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !os_tick) |=> busy); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R6

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (txd && !busy && !done)); // R8

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd); // R9
endmodule

bind par_serial_tx par_serial_tx_chk u_chk (.*);

// File: tb/sim_par_serial_tx.sv
`timescale 1ns/1ps
module sim_par_serial_tx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic os_tick = 1'b0;
  logic req = 1'b0;
  logic [7:0] din = '0;
  logic even_sel = 1'b0;
  logic txd, busy, done;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  par_serial_tx u0 (
    .clk(clk), .rst(rst), .os_tick(os_tick), .req(req), .din(din),
    .even_sel(even_sel), .txd(txd), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic test_reset();
    chk(txd === 1'b1, "R8", "txd in reset", txd, 1);
    chk(busy === 1'b0, "R8", "busy in reset", busy, 0);
    chk(done === 1'b0, "R8", "done in reset", done, 0);
  endtask

  task automatic test_idle_ticks();
    for (int k = 0; k < 12; k++) begin
      os_tick = 1'b1; @(negedge clk); os_tick = 1'b0; @(negedge clk);
    end
    chk(txd === 1'b1, "R9", "idle txd", txd, 1);
    chk(busy === 1'b0, "R9", "idle busy", busy, 0);
  endtask

  task automatic test_glitch();
    req = 1'b1; @(negedge clk); req = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(busy === 1'b0 && txd === 1'b1, "R3", "one-edge request launched",
          {busy, txd}, 2'b01);
    end
  endtask

  task automatic send_and_check(input logic [7:0] d, input logic sel,
                                input int gap, input bit disturb,
                                input bit hold);
    logic [10:0] exp;
    exp = {1'b1, ^d ^ ~sel, d, 1'b0};
    din = d; even_sel = sel; req = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(busy === 1'b0, "R3", "busy before third edge", busy, 0);
    if (!hold) req = 1'b0;
    @(negedge clk);
    chk(busy === 1'b1 && txd === 1'b0, "R3", "launch on third edge",
        {busy, txd}, 2'b10);
    if (disturb) begin din = ~d; even_sel = ~sel; end
    for (int i = 0; i < 11; i++) begin
      chk(txd === exp[i], (i == 9) ? "R4" : "R1", $sformatf("bit %0d", i), txd, exp[i]);
      chk(busy === 1'b1, "R5", "busy during frame", busy, 1);
      chk(done === 1'b0, "R6", "done during frame", done, 0);
      if (disturb && i == 3) req = 1'b1;
      for (int t = 0; t < 8; t++) begin
        os_tick = 1'b1; @(negedge clk); os_tick = 1'b0;
        if (disturb && i == 3 && t == 2) req = 1'b0;
        if (t < 7) begin
          chk(txd === exp[i], "R2", $sformatf("bit %0d held at tick %0d", i, t), txd, exp[i]);
          repeat (gap - 1) @(negedge clk);
        end
      end
    end
    chk(done === 1'b1, "R6", "done at stop end", done, 1);
    chk(busy === 1'b0, "R6", "busy falls with done", busy, 0);
    chk(txd === 1'b1, "R9", "line idle after frame", txd, 1);
    @(negedge clk);
    chk(done === 1'b0, "R6", "done one cycle", done, 0);
    repeat (6) @(negedge clk);
    chk(busy === 1'b0, disturb ? "R7" : "R3", "no extra frame", busy, 0);
    req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_idle_ticks();
    test_glitch();
    send_and_check(8'hA5, 1'b0, 1, 1'b0, 1'b0);
    send_and_check(8'h3C, 1'b1, 2, 1'b0, 1'b0);
    send_and_check(8'h01, 1'b0, 3, 1'b0, 1'b0);
    send_and_check(8'hFE, 1'b1, 1, 1'b0, 1'b0);
    send_and_check(8'h00, 1'b0, 1, 1'b0, 1'b1);
    send_and_check(8'h6B, 1'b1, 2, 1'b1, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule